// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block keeps an asynchronous DRAM alive. An interval timer produces one refresh tick per average refresh period; each tick adds one to a ledger of owed refreshes. While anything is owed, the block raises a bus request towards the access controller. Once that request is granted, it drives the memory strobes through a CAS-before-RAS refresh cycle: column strobe low first, row strobe low, both high again, then a precharge gap. Write enable is held high the whole time. The request falls only after the row strobe has returned high and the precharge gap has run out.

After reset the block waits a programmable power-up pause. It then runs a wake-up burst of eight refresh cycles before it signals that normal access may begin. The same burst runs again whenever the owed count climbs past its limit, because that means the retention period may have been exceeded.

A sleep input moves the memory into self refresh. The block starts a refresh cycle and holds the row strobe low for at least the self-refresh entry time, and it stays there while sleep is held. When sleep falls, the block drives both strobes high and keeps the bus for the exit precharge time. The interval timer restarts from zero, so no catch-up burst follows the exit. All timings are counted in clock cycles and are set by parameters.

Top module: `refr_sequencer`

## Requirements
- R1: During and right after reset, ras_n, cas_n and we_n are high (1), and bus_req, access_ok, in_self and owed_over are low.
- R2: For INIT_CYC cycles after reset release, bus_req stays low and no strobe is driven.
- R3: After the power-up pause, exactly WAKE_N refresh cycles complete before access_ok rises.
- R4: In every refresh cycle, cas_n is already low when ras_n falls, and we_n stays high. ras_n stays low for exactly RAS_LOW_CYC cycles. ras_n is high for at least RAS_PRE_CYC cycles before its next fall.
- R5: The strobes are driven only while bus_gnt is high. With bus_gnt low, bus_req may be high while the pins stay idle. bus_req falls only after ras_n and cas_n are high again.
- R6: Each interval tick (every REFI_CYC cycles) adds one owed refresh, and each completed refresh removes one. bus_req is raised while anything is owed, and the number of refresh cycles run after a grant equals the number owed.
- R7: owed_over is high exactly while the owed count exceeds OWE_LIMIT (it stays low at OWE_LIMIT). Crossing the limit pulls access_ok low and re-arms the WAKE_N-cycle wake-up. access_ok returns after WAKE_N further refresh cycles.
- R8: A sleep request taken while idle produces a refresh-style entry (cas_n low before ras_n falls). ras_n is held low for at least SELF_MIN_CYC cycles, even if sleep is dropped early, and in_self is high throughout.
- R9: When sleep falls after the minimum, ras_n and cas_n go high, and bus_req is held for exactly SELF_EXIT_CYC cycles before release.
- R10: After self-refresh exit, no burst of refreshes follows. The next request comes one full interval later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing parameters count its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Level request to enter and stay in self refresh |
| bus_gnt | input | 1 | Grant from the access controller; must stay high while bus_req is high |
| bus_req | output | 1 | Request for the memory bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| access_ok | output | 1 | Normal accesses allowed (wake-up complete, not sleeping) |
| in_self | output | 1 | Self-refresh sequence in progress |
| owed_over | output | 1 | Owed refresh count exceeds OWE_LIMIT |

## Verification
The assertions assume that the access controller keeps bus_gnt high once it has answered a request. The grant is never withdrawn until bus_req falls, so the strobes are only low under an active grant. The bench drives the grant as a function of bus_req and an enable, and it changes that enable only while the block is idle or waiting for its grant. The bench raises sleep only after bus_req has been low for a long stretch, so the sleep path never competes with a pending refresh.

// File: rtl/refr_pkg.sv
package refr_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_CSU   = 3'd3,
    ST_RLOW  = 3'd4,
    ST_PRE   = 3'd5,
    ST_SELF  = 3'd6,
    ST_SEXIT = 3'd7
  } seq_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refr_interval_timer.sv
module refr_interval_timer #(
  parameter int unsigned REFI_CYC = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = $clog2(REFI_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/refr_owed_ledger.sv
module refr_owed_ledger #(
  parameter int unsigned OWE_LIMIT = 8,
  parameter int unsigned WAKE_N    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cbr_done,
  input  logic init_end,
  output logic pending,
  output logic over,
  output logic wake_clear
);
  localparam int unsigned OW = $clog2(OWE_LIMIT + 2);
  localparam int unsigned WW = $clog2(WAKE_N + 1);
  localparam logic [OW-1:0] LIM = OW'(OWE_LIMIT);
  localparam logic [OW-1:0] SAT = OW'(OWE_LIMIT + 1);
  localparam logic [WW-1:0] WLD = WW'(WAKE_N);

  logic [OW-1:0] owed;
  logic [WW-1:0] wake;
  logic          drain;
  logic          lapse;

  assign drain = cbr_done && (owed != '0);
  assign lapse = tick && !drain && (owed == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed <= '0;
    end else if (tick && !drain) begin
      owed <= (owed == SAT) ? SAT : owed + 1'b1;
    end else if (drain && !tick) begin
      owed <= owed - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wake <= '0;
    else if (init_end || lapse) wake <= WLD;
    else if (cbr_done && (wake != '0)) wake <= wake - 1'b1;
  end

  assign pending    = (owed != '0) || (wake != '0);
  assign over       = (owed > LIM);
  assign wake_clear = (wake == '0);
endmodule

// File: rtl/refr_cbr_fsm.sv
module refr_cbr_fsm
  import refr_pkg::*;
#(
  parameter int unsigned INIT_CYC      = 10000,
  parameter int unsigned CSU_CYC       = 1,
  parameter int unsigned RAS_LOW_CYC   = 5,
  parameter int unsigned RAS_PRE_CYC   = 3,
  parameter int unsigned SELF_MIN_CYC  = 10000,
  parameter int unsigned SELF_EXIT_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic sleep_req,
  input  logic bus_gnt,
  output logic bus_req,
  output logic ras_n,
  output logic cas_n,
  output logic init_end,
  output logic init_done,
  output logic cbr_done,
  output logic sleep_mode
);
  localparam int unsigned TMAX = max2(max2(max2(INIT_CYC, SELF_MIN_CYC), max2(CSU_CYC, RAS_LOW_CYC)),
                                      max2(RAS_PRE_CYC, SELF_EXIT_CYC));
  localparam int unsigned TW = $clog2(TMAX + 1);

  function automatic logic [TW-1:0] ld(input int unsigned n);
    return TW'(n - 1);
  endfunction

  seq_state_t    state;
  logic [TW-1:0] tcnt;
  logic          slp;
  logic          tdone;

  assign tdone = (tcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_INIT;
      tcnt  <= ld(INIT_CYC);
      slp   <= 1'b0;
    end else begin
      case (state)
        ST_INIT: begin
          if (tdone) state <= ST_IDLE;
          else tcnt <= tcnt - 1'b1;
        end
        ST_IDLE: begin
          if (pending || sleep_req) begin
            state <= ST_WAIT;
            slp   <= !pending && sleep_req;
          end
        end
        ST_WAIT: begin
          if (bus_gnt) begin
            state <= ST_CSU;
            tcnt  <= ld(CSU_CYC);
          end
        end
        ST_CSU: begin
          if (tdone) begin
            state <= ST_RLOW;
            tcnt  <= slp ? ld(SELF_MIN_CYC) : ld(RAS_LOW_CYC);
          end else tcnt <= tcnt - 1'b1;
        end
        ST_RLOW: begin
          if (tdone) begin
            state <= slp ? ST_SELF : ST_PRE;
            tcnt  <= ld(RAS_PRE_CYC);
          end else tcnt <= tcnt - 1'b1;
        end
        ST_PRE: begin
          if (tdone) state <= ST_IDLE;
          else tcnt <= tcnt - 1'b1;
        end
        ST_SELF: begin
          if (!sleep_req) begin
            state <= ST_SEXIT;
            tcnt  <= ld(SELF_EXIT_CYC);
          end
        end
        ST_SEXIT: begin
          if (tdone) begin
            state <= ST_IDLE;
            slp   <= 1'b0;
          end else tcnt <= tcnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_req    = !(state inside {ST_INIT, ST_IDLE});
  assign cas_n      = !(state inside {ST_CSU, ST_RLOW, ST_SELF});
  assign ras_n      = !(state inside {ST_RLOW, ST_SELF});
  assign init_end   = (state == ST_INIT) && tdone;
  assign init_done  = (state != ST_INIT);
  assign cbr_done   = (state == ST_PRE) && tdone;
  assign sleep_mode = slp;
endmodule

// File: rtl/refr_sequencer.sv
module refr_sequencer #(
  parameter int unsigned REFI_CYC      = 1562,
  parameter int unsigned INIT_CYC      = 10000,
  parameter int unsigned WAKE_N        = 8,
  parameter int unsigned CSU_CYC       = 1,
  parameter int unsigned RAS_LOW_CYC   = 5,
  parameter int unsigned RAS_PRE_CYC   = 3,
  parameter int unsigned SELF_MIN_CYC  = 10000,
  parameter int unsigned SELF_EXIT_CYC = 9,
  parameter int unsigned OWE_LIMIT     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic bus_gnt,
  output logic bus_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic access_ok,
  output logic in_self,
  output logic owed_over
);
  logic tick, pending, wake_clear, init_end, init_done, cbr_done, sleep_mode;

  refr_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done && !sleep_mode), .tick(tick)
  );

  refr_owed_ledger #(.OWE_LIMIT(OWE_LIMIT), .WAKE_N(WAKE_N)) u_ledger (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cbr_done(cbr_done), .init_end(init_end),
    .pending(pending), .over(owed_over), .wake_clear(wake_clear)
  );

  refr_cbr_fsm #(
    .INIT_CYC(INIT_CYC), .CSU_CYC(CSU_CYC), .RAS_LOW_CYC(RAS_LOW_CYC),
    .RAS_PRE_CYC(RAS_PRE_CYC), .SELF_MIN_CYC(SELF_MIN_CYC), .SELF_EXIT_CYC(SELF_EXIT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pending(pending), .sleep_req(sleep_req), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .init_end(init_end),
    .init_done(init_done), .cbr_done(cbr_done), .sleep_mode(sleep_mode)
  );

  assign we_n      = 1'b1;
  assign in_self   = sleep_mode;
  assign access_ok = init_done && wake_clear && !sleep_mode;
endmodule

// File: rtl/refr_seq_checker.sv
module refr_seq_checker #(
  parameter int unsigned RAS_LOW_CYC = 5,
  parameter int unsigned RAS_PRE_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic bus_req,
  input logic bus_gnt,
  input logic access_ok,
  input logic owed_over
);
  localparam logic [15:0] LMIN = 16'(RAS_LOW_CYC);
  localparam logic [15:0] PMIN = 16'(RAS_PRE_CYC);

  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (!ras_n) begin
      hi_cnt <= '0;
      if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
    end else begin
      lo_cnt <= '0;
      if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && we_n)); // R4
  AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt >= LMIN)); // R4
  AST_RAS_PRE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= PMIN)); // R4
  AST_PINS_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> (bus_req && bus_gnt)); // R5
  AST_REQ_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> (ras_n && cas_n)); // R5
  AST_OVER_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    owed_over |-> !access_ok); // R7
endmodule

bind refr_sequencer refr_seq_checker #(
  .RAS_LOW_CYC(RAS_LOW_CYC), .RAS_PRE_CYC(RAS_PRE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .access_ok(access_ok), .owed_over(owed_over)
);

// File: tb/sim_refr_sequencer.sv
`timescale 1ns/1ps
module sim_refr_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int REFI  = 100;
  localparam int INIT  = 60;
  localparam int WAKE  = 8;
  localparam int RLOW  = 5;
  localparam int PRE   = 3;
  localparam int SMIN  = 50;
  localparam int SEXIT = 9;
  localparam int LIMIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic bus_gnt = 1'b0;
  logic bus_req, ras_n, cas_n, we_n, access_ok, in_self, owed_over;

  int checks = 0, failures = 0;
  int falls = 0, order_err = 0, gnt_err = 0, cur_lo = 0, last_lo = 0;
  logic prev_ras = 1'b1;
  logic gnt_en = 1'b1;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refr_sequencer #(
    .REFI_CYC(REFI), .INIT_CYC(INIT), .WAKE_N(WAKE), .CSU_CYC(1), .RAS_LOW_CYC(RLOW),
    .RAS_PRE_CYC(PRE), .SELF_MIN_CYC(SMIN), .SELF_EXIT_CYC(SEXIT), .OWE_LIMIT(LIMIT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .bus_gnt(bus_gnt), .bus_req(bus_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .access_ok(access_ok), .in_self(in_self),
    .owed_over(owed_over)
  );

  // pin monitor and grant model
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        falls++;
        if (cas_n || !we_n) order_err++;
      end
      if ((!ras_n || !cas_n) && !bus_gnt) gnt_err++;
      if (!ras_n) cur_lo = prev_ras ? 1 : cur_lo + 1;
      else if (!prev_ras) last_lo = cur_lo;
      prev_ras = ras_n;
    end
    bus_gnt = bus_req && gnt_en;
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic wait_req(input logic lvl, input int limit);
    for (int i = 0; i < limit && bus_req != lvl; i++) step();
  endtask

  task automatic t_reset_init;
    step(3);
    check("R1", "ras_n in reset", ras_n, 1);
    check("R1", "cas_n/we_n in reset", {cas_n, we_n}, 2'b11);
    check("R1", "req/ok/self/over in reset", {bus_req, access_ok, in_self, owed_over}, 0);
    rst_n = 1'b1;
    step(INIT - 3);
    check("R2", "req during power-up pause", bus_req, 0);
    check("R2", "strobes during pause", {ras_n, cas_n}, 2'b11);
    check("R2", "access_ok during pause", access_ok, 0);
    for (int i = 0; i < 400 && !access_ok; i++) step();
    check("R3", "wake-up refresh count", falls, WAKE);
    check("R3", "access_ok after wake-up", access_ok, 1);
    check("R4", "ras low length", last_lo, RLOW);
    check("R4", "order errors", order_err, 0);
  endtask

  task automatic t_owed;
    int f0;
    gnt_en = 1'b0;
    wait_req(1'b1, 300);
    check("R6", "req on first tick", bus_req, 1);
    f0 = falls;
    step(30);
    check("R5", "no cycle without grant", falls - f0, 0);
    check("R5", "pins idle without grant", {ras_n, cas_n}, 2'b11);
    step(180);
    gnt_en = 1'b1;
    f0 = falls;
    step(60);
    check("R6", "refreshes for three owed", falls - f0, 3);
    check("R6", "req released when drained", bus_req, 0);
    check("R5", "pins low without grant", gnt_err, 0);
    check("R4", "ras low length", last_lo, RLOW);
  endtask

  task automatic t_lapse;
    int f0;
    gnt_en = 1'b0;
    wait_req(1'b1, 300);
    step(REFI * 7 + 10);
    check("R7", "flag at limit", owed_over, 0);
    check("R7", "access at limit", access_ok, 1);
    step(REFI);
    check("R7", "flag above limit", owed_over, 1);
    check("R7", "access blocked", access_ok, 0);
    gnt_en = 1'b1;
    f0 = falls;
    for (int i = 0; i < 300 && !access_ok; i++) step();
    check("R7", "rewake refresh count", falls - f0, WAKE);
    check("R7", "flag cleared", owed_over, 0);
    check("R4", "order errors", order_err, 0);
  endtask

  task automatic t_self;
    int quiet = 0, n = 0, hi = 0;
    for (int i = 0; i < 400 && quiet < 20; i++) begin
      step();
      quiet = bus_req ? 0 : quiet + 1;
    end
    sleep_req = 1'b1;
    step(5);
    check("R8", "in_self during entry", in_self, 1);
    check("R8", "access_ok during sleep", access_ok, 0);
    step(5);
    sleep_req = 1'b0;
    step(20);
    check("R8", "ras held after early sleep drop", ras_n, 0);
    for (int i = 0; i < 200 && !ras_n; i++) step();
    check("R8", "ras low at least minimum", (last_lo >= SMIN) ? 1 : 0, 1);
    check("R8", "entry order", order_err, 0);
    while (bus_req && n < 100) begin
      if (!ras_n || !cas_n) hi++;
      n++;
      step();
    end
    check("R9", "exit precharge length", n, SEXIT);
    check("R9", "strobes high in exit", hi, 0);
    check("R9", "in_self after exit", in_self, 0);
    n = 0;
    for (int i = 0; i < REFI - 10; i++) begin
      if (bus_req) n++;
      step();
    end
    check("R10", "no burst after exit", n, 0);
    wait_req(1'b1, 30);
    check("R10", "next distributed refresh", bus_req, 1);
  endtask

  initial begin
    t_reset_init();
    t_owed();
    t_lapse();
    t_self();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule